// File: doc/BRIEF.md
# Memory-to-Memory 8-Bit Processor

This block is a small multi-cycle processor whose operands all live in memory. Code and data share one synchronous byte-wide memory, and the processor keeps no condition flags. Each instruction starts with one byte that holds a 3-bit opcode, an ALU mode bit and a 4-bit ALU function code. One to three operand bytes follow it, and each operand is a memory address or a jump target.

The instruction set has eight opcodes. Two of them are ALU operations that differ only in the carry-in they force. Two copy an input port into memory. Two copy a memory byte out to a latched output port and pulse that port's strobe. One is an unconditional jump. The last compares two memory bytes and branches when they are equal. A one-cycle strobe on each output port marks a new value, so the block can drive simple peripherals directly.

Top module: `mm8_cpu`

## Requirements
- R1: While reset is held, both output ports read 0x00, both strobes are low and no memory write is issued. In the first cycle after reset is released, the block requests a read at address 0x00.
- R2: The first byte holds the opcode in bits 7:5, the mode bit in bit 4 and the function code in bits 3:0. Operand bytes are fetched in order from the following addresses, and the program counter wraps from 0xFF to 0x00.
- R3: With the mode bit at 0, the ALU result is an arithmetic function of A and B picked by the function code, plus the carry-in. Opcode 0 forces the carry-in to 0 and opcode 1 forces it to 1. Examples: code 1001 gives A+B+cin, code 0110 gives A-B-1+cin, code 1111 gives A-1+cin and code 0000 gives A+cin.
- R4: With the mode bit at 1, the ALU result is a bitwise function picked by the function code. Examples: 0110 gives A xor B, 1011 gives A and B, 1110 gives A or B and 1100 gives all ones.
- R5: An ALU instruction with the mode bit at 1 and function code 0000 (NOT A) or 1111 (A) takes two operands and writes f(mem[A]) to mem[B]. Every other ALU instruction takes three operands and writes f(mem[A], mem[B]) to mem[C].
- R6: Opcode 2 writes input port 0 to mem[A], and opcode 3 writes input port 1 to mem[A].
- R7: Opcode 4 loads mem[A] into output port 0, and opcode 5 loads it into output port 1. The port raises its strobe for exactly one cycle in the cycle its value changes, and it holds the value otherwise.
- R8: Opcode 6 loads its single operand byte into the program counter.
- R9: Opcode 7 loads operand J into the program counter when mem[A] equals mem[B]. Otherwise execution continues with the next instruction. No result survives the instruction.
- R10: Counted from the cycle in which its first byte is requested, an instruction lasts a fixed number of cycles. Opcode 6 lasts 5 cycles, opcodes 2 and 3 last 6, opcodes 4 and 5 last 7, a two-operand ALU instruction lasts 10, and a three-operand ALU instruction or opcode 7 lasts 14. An ALU or input write appears in the instruction's last cycle, and an output strobe appears in the cycle after opcode 4 or 5 ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 8 | Memory address for a read or a write |
| mem_rd | output | 1 | Read request; data returns in the next cycle |
| mem_we | output | 1 | Write enable |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for the request made in the previous cycle |
| in0_data | input | 8 | Input port 0 |
| in1_data | input | 8 | Input port 1 |
| out0_data | output | 8 | Output port 0, held value |
| out0_stb | output | 1 | One-cycle pulse when output port 0 is written |
| out1_data | output | 8 | Output port 1, held value |
| out1_stb | output | 1 | One-cycle pulse when output port 1 is written |

## Verification
The bench builds the block with its default widths of eight data bits and eight address bits. At these widths the full 256-byte address space is in play, so a program can fetch an operand across the 0xFF to 0x00 boundary. The bench also keeps the default equality comparator, which reuses the subtract-with-carry path. With these values the bench can sweep every function code in both ALU modes and with both carry-ins. It can also check each write and each strobe against the exact cycle that the instruction lengths predict.

// File: rtl/mm8_pkg.sv
package mm8_pkg;

   typedef enum logic [3:0] {
      ST_IF_REQ, ST_IF_CAP, ST_OP_REQ, ST_OP_CAP, ST_EXEC,
      ST_DA_REQ, ST_DA_CAP, ST_DB_REQ, ST_DB_CAP, ST_BR, ST_WR
   } seq_state_t;

   localparam logic [2:0] OPC_ALU_C0 = 3'd0;
   localparam logic [2:0] OPC_ALU_C1 = 3'd1;
   localparam logic [2:0] OPC_IN0    = 3'd2;
   localparam logic [2:0] OPC_IN1    = 3'd3;
   localparam logic [2:0] OPC_OUT0   = 3'd4;
   localparam logic [2:0] OPC_OUT1   = 3'd5;
   localparam logic [2:0] OPC_JMP    = 3'd6;
   localparam logic [2:0] OPC_BEQ    = 3'd7;

   localparam int N_OUT_PORTS = 2;

endpackage

// File: rtl/mm8_decode.sv
module mm8_decode
   import mm8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] ir,
   output logic [2:0]        opc,
   output logic              mode,
   output logic [3:0]        fsel,
   output logic              single,
   output logic [1:0]        n_opnd,
   output logic [1:0]        dst_idx
);
   localparam int OPC_LSB = DATA_W - 3;
   localparam int MODE_POS = DATA_W - 4;

   assign opc  = ir[DATA_W-1:OPC_LSB];
   assign mode = ir[MODE_POS];
   assign fsel = ir[3:0];

   always_comb begin
      single  = 1'b0;
      n_opnd  = 2'd1;
      dst_idx = 2'd0;
      unique case (opc)
         OPC_ALU_C0, OPC_ALU_C1: begin
            single  = mode && ((fsel == 4'h0) || (fsel == 4'hF));
            n_opnd  = single ? 2'd2 : 2'd3;
            dst_idx = single ? 2'd1 : 2'd2;
         end
         OPC_BEQ: n_opnd = 2'd3;
         default: n_opnd = 2'd1;
      endcase
   end
endmodule

// File: rtl/mm8_alu.sv
module mm8_alu #(
   parameter int DATA_W   = 8,
   parameter int EQ_STYLE = 0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              mode,
   input  logic [3:0]        fsel,
   input  logic              cin,
   output logic [DATA_W-1:0] f,
   output logic              eq
);
   localparam logic [DATA_W-1:0] ONES = '1;
   localparam logic [DATA_W-1:0] ZERO = '0;

   logic [DATA_W-1:0] t_or, t_ornb, t_andnb, t_and;
   logic [DATA_W-1:0] lg, ax, ay;

   assign t_or    = a | b;
   assign t_ornb  = a | ~b;
   assign t_andnb = a & ~b;
   assign t_and   = a & b;

   always_comb begin
      unique case (fsel)
         4'h0: lg = ~a;
         4'h1: lg = ~t_or;
         4'h2: lg = ~a & b;
         4'h3: lg = ZERO;
         4'h4: lg = ~t_and;
         4'h5: lg = ~b;
         4'h6: lg = a ^ b;
         4'h7: lg = t_andnb;
         4'h8: lg = ~a | b;
         4'h9: lg = ~(a ^ b);
         4'hA: lg = b;
         4'hB: lg = t_and;
         4'hC: lg = ONES;
         4'hD: lg = t_ornb;
         4'hE: lg = t_or;
         default: lg = a;
      endcase
   end

   always_comb begin
      unique case (fsel)
         4'h0: begin ax = a;       ay = ZERO;    end
         4'h1: begin ax = t_or;    ay = ZERO;    end
         4'h2: begin ax = t_ornb;  ay = ZERO;    end
         4'h3: begin ax = ONES;    ay = ZERO;    end
         4'h4: begin ax = a;       ay = t_andnb; end
         4'h5: begin ax = t_or;    ay = t_andnb; end
         4'h6: begin ax = a;       ay = ~b;      end
         4'h7: begin ax = t_andnb; ay = ONES;    end
         4'h8: begin ax = a;       ay = t_and;   end
         4'h9: begin ax = a;       ay = b;       end
         4'hA: begin ax = t_ornb;  ay = t_and;   end
         4'hB: begin ax = t_and;   ay = ONES;    end
         4'hC: begin ax = a;       ay = a;       end
         4'hD: begin ax = t_or;    ay = a;       end
         4'hE: begin ax = t_ornb;  ay = a;       end
         default: begin ax = a;    ay = ONES;    end
      endcase
   end

   assign f = mode ? lg : (ax + ay + {{(DATA_W-1){1'b0}}, cin});

   generate
      if (EQ_STYLE == 0) begin : g_eq_sub
         logic [DATA_W-1:0] diff;
         assign diff = a + ~b + {{(DATA_W-1){1'b0}}, 1'b1};
         assign eq   = (diff == ZERO);
      end else begin : g_eq_cmp
         assign eq = (a == b);
      end
   endgenerate
endmodule

// File: rtl/mm8_outport.sv
module mm8_outport #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] q,
   output logic              stb
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= '0;
         stb <= 1'b0;
      end else begin
         stb <= load;
         if (load) q <= din;
      end
   end
endmodule

// File: rtl/mm8_cpu.sv
module mm8_cpu
   import mm8_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 8,
   parameter int EQ_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] in0_data,
   input  logic [DATA_W-1:0] in1_data,
   output logic [DATA_W-1:0] out0_data,
   output logic              out0_stb,
   output logic [DATA_W-1:0] out1_data,
   output logic              out1_stb
);
   localparam int N_OPND = 3;

   generate
      if (DATA_W < 8) begin : g_bad_dw
         $error("mm8_cpu: DATA_W must hold opcode, mode and select fields");
      end
      if (ADDR_W != DATA_W) begin : g_bad_aw
         $error("mm8_cpu: an operand byte must be a full address");
      end
      if ((EQ_STYLE != 0) && (EQ_STYLE != 1)) begin : g_bad_eq
         $error("mm8_cpu: EQ_STYLE must be 0 or 1");
      end
   endgenerate

   seq_state_t        state;
   logic [ADDR_W-1:0] pc;
   logic [DATA_W-1:0] ir, va, vb;
   logic [DATA_W-1:0] opnd [N_OPND];
   logic [1:0]        idx;

   logic [2:0]        opc;
   logic              mode, single;
   logic [3:0]        fsel;
   logic [1:0]        n_opnd, dst_idx;
   logic [DATA_W-1:0] alu_f;
   logic              alu_eq;

   mm8_decode #(.DATA_W(DATA_W)) u_dec (
      .ir(ir), .opc(opc), .mode(mode), .fsel(fsel),
      .single(single), .n_opnd(n_opnd), .dst_idx(dst_idx)
   );

   mm8_alu #(.DATA_W(DATA_W), .EQ_STYLE(EQ_STYLE)) u_alu (
      .a(va), .b(vb), .mode(mode), .fsel(fsel), .cin(opc[0]),
      .f(alu_f), .eq(alu_eq)
   );

   // output ports, one instance per port
   logic [DATA_W-1:0] oq   [N_OUT_PORTS];
   logic              ostb [N_OUT_PORTS];
   logic              oload[N_OUT_PORTS];

   generate
      for (genvar g = 0; g < N_OUT_PORTS; g++) begin : g_out
         assign oload[g] = (state == ST_DA_CAP) && (opc == 3'(4 + g));
         mm8_outport #(.DATA_W(DATA_W)) u_port (
            .clk(clk), .rst_n(rst_n), .load(oload[g]), .din(mem_rdata),
            .q(oq[g]), .stb(ostb[g])
         );
      end
   endgenerate

   assign out0_data = oq[0];
   assign out0_stb  = ostb[0];
   assign out1_data = oq[1];
   assign out1_stb  = ostb[1];

   // memory port
   assign mem_rd = (state == ST_IF_REQ) || (state == ST_OP_REQ) ||
                   (state == ST_DA_REQ) || (state == ST_DB_REQ);
   assign mem_we = (state == ST_WR);

   always_comb begin
      unique case (state)
         ST_DA_REQ: mem_addr = opnd[0];
         ST_DB_REQ: mem_addr = opnd[1];
         ST_WR:     mem_addr = opnd[dst_idx];
         default:   mem_addr = pc;
      endcase
   end

   always_comb begin
      if (opc == OPC_IN0)      mem_wdata = in0_data;
      else if (opc == OPC_IN1) mem_wdata = in1_data;
      else                     mem_wdata = alu_f;
   end

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IF_REQ;
         pc    <= '0;
         ir    <= '0;
         idx   <= '0;
         va    <= '0;
         vb    <= '0;
         for (int k = 0; k < N_OPND; k++) opnd[k] <= '0;
      end else begin
         unique case (state)
            ST_IF_REQ: begin
               pc    <= pc + 1'b1;
               state <= ST_IF_CAP;
            end
            ST_IF_CAP: begin
               ir    <= mem_rdata;
               idx   <= '0;
               state <= ST_OP_REQ;
            end
            ST_OP_REQ: begin
               pc    <= pc + 1'b1;
               state <= ST_OP_CAP;
            end
            ST_OP_CAP: begin
               opnd[idx] <= mem_rdata;
               idx       <= idx + 2'd1;
               state     <= ((idx + 2'd1) == n_opnd) ? ST_EXEC : ST_OP_REQ;
            end
            ST_EXEC: begin
               if (opc == OPC_JMP) begin
                  pc    <= opnd[0];
                  state <= ST_IF_REQ;
               end else if ((opc == OPC_IN0) || (opc == OPC_IN1)) begin
                  state <= ST_WR;
               end else begin
                  state <= ST_DA_REQ;
               end
            end
            ST_DA_REQ: state <= ST_DA_CAP;
            ST_DA_CAP: begin
               va <= mem_rdata;
               if ((opc == OPC_OUT0) || (opc == OPC_OUT1)) state <= ST_IF_REQ;
               else if (single)                            state <= ST_WR;
               else                                        state <= ST_DB_REQ;
            end
            ST_DB_REQ: state <= ST_DB_CAP;
            ST_DB_CAP: begin
               vb    <= mem_rdata;
               state <= (opc == OPC_BEQ) ? ST_BR : ST_WR;
            end
            ST_BR: begin
               if (alu_eq) pc <= opnd[2];
               state <= ST_IF_REQ;
            end
            default: state <= ST_IF_REQ;
         endcase
      end
   end
endmodule

// File: rtl/mm8_cpu_chk.sv
module mm8_cpu_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd,
   input logic              mem_we,
   input logic [DATA_W-1:0] out0_data,
   input logic              out0_stb,
   input logic [DATA_W-1:0] out1_data,
   input logic              out1_stb
);
   // R10
   rd_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_we));

   // R10
   rd_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   // R10
   wr_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> mem_rd);

   // R7
   out0_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out0_stb |=> !out0_stb);

   // R7
   out1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out1_stb |=> !out1_stb);

   // R7
   out0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out0_stb |-> $stable(out0_data));

   // R7
   out1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out1_stb |-> $stable(out1_data));

   // R7
   one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(out0_stb && out1_stb));
endmodule

bind mm8_cpu mm8_cpu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_we(mem_we),
   .out0_data(out0_data), .out0_stb(out0_stb),
   .out1_data(out1_data), .out1_stb(out1_stb)
);

// File: tb/mm8_cpu_tb_top.sv
module mm8_cpu_tb_top;

   typedef struct {
      int    cyc;
      int    addr;
      int    data;
      string tag;
   } ev_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] mem_addr, mem_wdata, mem_rdata, in0_data, in1_data;
   logic [7:0] out0_data, out1_data;
   logic       mem_rd, mem_we, out0_stb, out1_stb;

   always #10ns clk = ~clk;

   mm8_cpu #(.DATA_W(8), .ADDR_W(8), .EQ_STYLE(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .in0_data(in0_data), .in1_data(in1_data),
      .out0_data(out0_data), .out0_stb(out0_stb),
      .out1_data(out1_data), .out1_stb(out1_stb)
   );

   // program image and memory
   logic [7:0] img [256];
   logic [7:0] mem [256];
   logic       do_load = 1'b0;
   int         ap;

   always @(posedge clk) begin
      if (do_load) begin
         for (int i = 0; i < 256; i++) mem[i] <= img[i];
      end else begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         if (mem_rd) mem_rdata <= mem[mem_addr];
      end
   end

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_img();
      for (int i = 0; i < 256; i++) img[i] = 8'h00;
      ap = 0;
   endtask

   task automatic put(int b);
      img[ap[7:0]] = b[7:0];
      ap = (ap + 1) % 256;
   endtask

   // behavioural reference
   ev_t wq[$];
   ev_t q0[$];
   ev_t q1[$];

   function automatic int ref_alu(int a, int b, bit m, int s, int c);
      int na, nb, r;
      na = (~a) & 255;
      nb = (~b) & 255;
      if (m) begin
         case (s)
            0: r = na;          1: r = ~(a | b);
            2: r = na & b;      3: r = 0;
            4: r = ~(a & b);    5: r = nb;
            6: r = a ^ b;       7: r = a & nb;
            8: r = na | b;      9: r = ~(a ^ b);
            10: r = b;          11: r = a & b;
            12: r = 255;        13: r = a | nb;
            14: r = a | b;      default: r = a;
         endcase
      end else begin
         case (s)
            0: r = a + c;                   1: r = (a | b) + c;
            2: r = (a | nb) + c;            3: r = 255 + c;
            4: r = a + (a & nb) + c;        5: r = (a | b) + (a & nb) + c;
            6: r = a - b - 1 + c;           7: r = (a & nb) - 1 + c;
            8: r = a + (a & b) + c;         9: r = a + b + c;
            10: r = (a | nb) + (a & b) + c; 11: r = (a & b) - 1 + c;
            12: r = 2 * a + c;              13: r = (a | b) + a + c;
            14: r = (a | nb) + a + c;       default: r = a - 1 + c;
         endcase
      end
      return r & 255;
   endfunction

   task automatic model_run(int budget, int ia, int ib);
      int m [256];
      int s, pc, ir, opc, md, sl, n, len, a, b, r;
      int op [3];
      bit single;
      ev_t e;
      for (int i = 0; i < 256; i++) m[i] = img[i];
      wq.delete(); q0.delete(); q1.delete();
      s = 0;
      pc = 0;
      while (s < budget) begin
         ir  = m[pc];
         pc  = (pc + 1) % 256;
         opc = ir / 32;
         md  = (ir / 16) % 2;
         sl  = ir % 16;
         single = (opc < 2) && (md == 1) && (sl == 0 || sl == 15);
         if (opc < 2)       n = single ? 2 : 3;
         else if (opc == 7) n = 3;
         else               n = 1;
         for (int k = 0; k < n; k++) begin
            op[k] = m[pc];
            pc = (pc + 1) % 256;
         end
         len = 5;
         case (opc)
            0, 1: begin
               a = m[op[0]];
               if (single) begin
                  r = ref_alu(a, 0, 1'b1, sl, opc);
                  e = '{s + 9, op[1], r, "R5"};
                  m[op[1]] = r;
                  len = 10;
               end else begin
                  b = m[op[1]];
                  r = ref_alu(a, b, md[0], sl, opc);
                  e = '{s + 13, op[2], r, (md == 1) ? "R4" : "R3"};
                  m[op[2]] = r;
                  len = 14;
               end
               wq.push_back(e);
            end
            2, 3: begin
               r = (opc == 2) ? ia : ib;
               e = '{s + 5, op[0], r, "R6"};
               wq.push_back(e);
               m[op[0]] = r;
               len = 6;
            end
            4, 5: begin
               e = '{s + 7, 0, m[op[0]], "R7"};
               if (opc == 4) q0.push_back(e);
               else          q1.push_back(e);
               len = 7;
            end
            6: begin
               pc = op[0];
               len = 5;
            end
            default: begin
               if (m[op[0]] == m[op[1]]) pc = op[2];
               len = 14;
            end
         endcase
         s = s + len;
      end
   endtask

   task automatic port_cycle(ref ev_t q[$], input int cyc, input logic stb,
                             input logic [7:0] dat, ref int hold, ref int cnt);
      bit exp_stb;
      exp_stb = (q.size() > 0) && (q[0].cyc == cyc);
      chk(stb == exp_stb, "R10", "strobe timing", stb, exp_stb);
      if (exp_stb) begin
         hold = q[0].data;
         q.pop_front();
      end
      if (stb) cnt++;
      chk(dat == hold[7:0], "R7", "output port value", dat, hold);
   endtask

   int cnt0, cnt1;

   task automatic run_prog(int budget, int ia, int ib);
      int h0, h1;
      bit exp_we;
      in0_data = ia[7:0];
      in1_data = ib[7:0];
      model_run(budget, ia, ib);
      @(negedge clk);
      rst_n = 1'b0;
      do_load = 1'b1;
      @(negedge clk);
      do_load = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(out0_data == 8'h00 && out1_data == 8'h00, "R1", "ports in reset",
          {out0_data, out1_data}, 0);
      chk(!out0_stb && !out1_stb && !mem_we, "R1", "strobes/write in reset",
          {out0_stb, out1_stb, mem_we}, 0);
      rst_n = 1'b1;
      #1;
      chk(mem_rd && mem_addr == 8'h00, "R1", "first fetch address",
          {mem_rd, mem_addr}, 9'h100);
      h0 = 0;
      h1 = 0;
      cnt0 = 0;
      cnt1 = 0;
      for (int cyc = 1; cyc <= budget; cyc++) begin
         @(negedge clk);
         exp_we = (wq.size() > 0) && (wq[0].cyc == cyc);
         chk(mem_we == exp_we, "R10", "write timing", mem_we, exp_we);
         if (exp_we) begin
            if (mem_we) begin
               chk(mem_addr == wq[0].addr[7:0], wq[0].tag, "write address",
                   mem_addr, wq[0].addr);
               chk(mem_wdata == wq[0].data[7:0], wq[0].tag, "write data",
                   mem_wdata, wq[0].data);
            end
            wq.pop_front();
         end
         port_cycle(q0, cyc, out0_stb, out0_data, h0, cnt0);
         port_cycle(q1, cyc, out1_stb, out1_data, h1, cnt1);
      end
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      in0_data = 8'h00;
      in1_data = 8'h00;

      // program 1: every instruction class, taken and untaken compare
      clear_img();
      put(8'h40); put(8'h80);                          // in0 -> 80
      put(8'h60); put(8'h81);                          // in1 -> 81
      put(8'h09); put(8'h80); put(8'h81); put(8'h82);  // add
      put(8'h26); put(8'h80); put(8'h81); put(8'h83);  // sub, cin 1
      put(8'h16); put(8'h80); put(8'h81); put(8'h84);  // xor
      put(8'h10); put(8'h80); put(8'h85);              // not, single
      put(8'h20); put(8'h85); put(8'h81); put(8'h86);  // A+1
      put(8'h80); put(8'h82);                          // out0 m82
      put(8'hA0); put(8'h83);                          // out1 m83
      put(8'hE0); put(8'h84); put(8'h84); put(8'h22);  // beq taken
      put(8'h80); put(8'h86);                          // skipped
      put(8'h00);
      put(8'hE0); put(8'h80); put(8'h81); put(8'h1F);  // beq not taken
      put(8'hA0); put(8'h85);                          // out1 m85
      put(8'h80); put(8'h84);                          // out0 m84
      put(8'hC0); put(8'h2A);                          // halt
      run_prog(300, 8'h35, 8'h0C);
      // R9: the taken compare skips one out0 write, the untaken one falls through
      chk(cnt0 == 2, "R9", "out0 strobe count", cnt0, 2);
      chk(out0_data == 8'h39, "R9", "out0 final", out0_data, 8'h39);
      chk(cnt1 == 2 && out1_data == 8'hCA, "R9", "out1 after fallthrough",
          out1_data, 8'hCA);
      chk(out0_data == 8'h39, "R4", "xor result seen at port", out0_data, 8'h39);

      // program 2: pc wrap, jump, counting loop
      clear_img();
      put(8'hC0); put(8'hFF);                          // jmp FF
      ap = 8'hFF; put(8'hC0);                          // jmp, operand at 00
      ap = 8'hC0;
      put(8'h40); put(8'h90);                          // in0 -> 90
      put(8'h80); put(8'h90);                          // out0 m90
      put(8'h0F); put(8'h90); put(8'h91); put(8'h90);  // m90 - 1
      put(8'hE0); put(8'h90); put(8'h92); put(8'hD0);  // exit at zero
      put(8'hC0); put(8'hC2);                          // loop
      ap = 8'hD0;
      put(8'hA0); put(8'h90);                          // out1 m90
      put(8'hC0); put(8'hD2);                          // halt
      run_prog(300, 8'h03, 8'h77);
      // R2: the operand of the jump at FF comes from address 00
      chk(cnt0 == 3, "R2", "loop reached after wrap", cnt0, 3);
      // R8: loop back jump repeats the output three times
      chk(out0_data == 8'h01, "R8", "last loop output", out0_data, 8'h01);
      chk(cnt1 == 1 && out1_data == 8'h00, "R9", "exit on equality",
          {cnt1[7:0], out1_data}, 16'h0100);

      // program 3: sweep every function code, mode and carry-in
      clear_img();
      put(8'h40); put(8'hE0);
      put(8'h60); put(8'hE1);
      for (int md = 0; md < 2; md++) begin
         for (int sl = 0; sl < 16; sl++) begin
            for (int c = 0; c < 2 - md; c++) begin
               put(c * 32 + md * 16 + sl);
               put(8'hE0);
               if (!(md == 1 && (sl == 0 || sl == 15))) put(8'hE1);
               put(8'hF0 + sl);
            end
         end
      end
      put(8'hE0 + 8'h0); put(8'hF0); put(8'hF0); put(ap + 1); // beq taken
      put(8'hC0); put(ap - 1);                               // halt
      run_prog(800, 8'hB6, 8'h5D);
      chk(cnt0 == 0 && cnt1 == 0, "R7", "no strobe without output op",
          cnt0 + cnt1, 0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule